// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps the precision time of day for a network port. It holds a 48-bit seconds count and a 30-bit nanoseconds count that wraps at one billion. On every reference clock it adds a programmable step to the time. The step has an 8-bit whole-nanosecond part and a 16-bit fraction of a nanosecond. A 16-bit accumulator collects the fraction, and each carry out of it adds one extra nanosecond on that cycle.

Software uses a single-beat register port. Writes take effect at the next clock edge. Reads are combinational from the live counters. Through this port software can read the time, load it, retune the step and apply a one-shot signed offset. The live seconds and nanoseconds also drive two plain output buses that a timestamp capture stage samples. The time advances continuously and the capture stage never stalls it, so these buses carry no valid/ready handshake and have no back-pressure. Only one register write can happen per cycle.

Register map (word addresses on `reg_addr`):

| Address | Write action | Read value |
|---|---|---|
| 0 | load nanoseconds | live nanoseconds |
| 1 | load seconds | live seconds[31:0] |
| 2 | stage upper seconds | live seconds[47:32] |
| 3 | stage fraction | staged fraction |
| 4 | commit increment | `{act_frac, act_inc}` |
| 5 | one-shot offset | 0 |
| 6, 7 | none | 0 |

Top module: `ptp_tod_counter`

## Requirements
- R1: Reset behaviour.
  - After reset, seconds, nanoseconds, the fraction accumulator, both staging registers and the active increment are all zero.
  - While the active increment is zero, the time holds its value.
- R2: With no write, each clock adds the active whole-nanosecond increment to the nanoseconds. It also adds one more nanosecond whenever the 16-bit fraction accumulator, advanced by the active fraction, carries out.
- R3: When the stepped nanoseconds reach 1,000,000,000, the counter subtracts 10^9 and adds one to the seconds in the same cycle. Outside a nanosecond load, the nanoseconds output is always below 10^9.
- R4: Fraction staging and commit.
  - A write to address 3 only stages `wdata[15:0]`; the staged value reads back at address 3.
  - A write to address 4 commits `wdata[7:0]` as the whole increment and, in the same edge, the staged fraction as the active fraction.
  - Address 4 reads `{8'b0, active fraction[15:0] at bits 23:8, active whole increment at bits 7:0}`.
- R5: A write to address 2 only stages `wdata[15:0]` as the upper seconds. The live seconds are not changed by it.
- R6: A write to address 1 loads the seconds with `{staged upper, wdata[31:0]}`. The nanoseconds keep stepping on that edge, and any carry they make on that edge is dropped.
- R7: A write to address 0 loads `wdata[29:0]` into the nanoseconds, and the seconds stay unchanged on that edge. Loading zero first therefore stops any carry into seconds during a later seconds load.
- R8: Adding offset.
  - A write to address 5 with bit 31 clear adds `wdata[29:0]` nanoseconds to the just-stepped time in the same cycle.
  - If the result reaches 10^9, the counter carries one second; if it reaches 2*10^9, it carries two.
- R9: Subtracting offset.
  - A write to address 5 with bit 31 set subtracts `wdata[29:0]` nanoseconds.
  - Each 10^9 needed to bring the result back to zero or above borrows one second.
  - Seconds wrap modulo 2^48.
- R10: Reads are combinational:
  - address 0 returns the nanoseconds;
  - address 1 returns seconds[31:0];
  - address 2 returns seconds[47:32];
  - address 5 and addresses 6 and 7 return zero.
- R11: `tod_sec_o` and `tod_ns_o` always show the live counter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | reference clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 3 | register word address |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | combinational read data |
| tod_sec_o | output | 48 | live seconds to the capture stage |
| tod_ns_o | output | 30 | live nanoseconds to the capture stage |

## Verification
The checker enforces these rules on every cycle:
- nanoseconds stay below one billion except right after a nanosecond load;
- staging the upper seconds or the fraction leaves the live time or the active rate untouched;
- a commit installs exactly the written whole part and the staged fraction;
- a seconds load lands exactly;
- a zero rate freezes the time.

Some behaviour only the bench scenarios can show, because it needs the exact arithmetic over many cycles:
- the fraction accumulator's extra nanoseconds;
- single and double carries and borrows from offsets;
- wrapping seconds below zero.

These are compared against a cycle model through the read port and the capture buses.

// File: rtl/ptp_tod_pkg.sv
`timescale 1ns/1ps
package ptp_tod_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;
  localparam int BILLION  = 1000000000;

  localparam logic [ADDR_W-1:0] A_NS     = 3'd0;
  localparam logic [ADDR_W-1:0] A_SEC_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_SEC_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_FRAC   = 3'd3;
  localparam logic [ADDR_W-1:0] A_INC    = 3'd4;
  localparam logic [ADDR_W-1:0] A_OFFS   = 3'd5;

  localparam int OFFS_DIR_BIT = 31;
endpackage

// File: rtl/tod_regs.sv
`timescale 1ns/1ps
module tod_regs
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int INC_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [SEC_W-DATA_W-1:0] hi_stage,
  output logic [FRAC_W-1:0]       frac_stage,
  output logic [INC_W-1:0]        act_inc,
  output logic [FRAC_W-1:0]       act_frac,
  output logic                    ld_ns,
  output logic                    ld_sec,
  output logic                    off_en,
  output logic                    off_sub,
  output logic [NS_W-1:0]         off_mag
);
  localparam int HI_W = SEC_W - DATA_W;

  // Write strobes, one per register.
  always_comb begin
    ld_ns   = we && (addr == A_NS);
    ld_sec  = we && (addr == A_SEC_LO);
    off_en  = we && (addr == A_OFFS);
    off_sub = wdata[OFFS_DIR_BIT];
    off_mag = wdata[NS_W-1:0];
  end

  // Staging registers and the active increment.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_stage   <= '0;
      frac_stage <= '0;
      act_inc    <= '0;
      act_frac   <= '0;
    end else if (we) begin
      case (addr)
        A_SEC_HI: hi_stage   <= wdata[HI_W-1:0];
        A_FRAC:   frac_stage <= wdata[FRAC_W-1:0];
        A_INC: begin
          act_inc  <= wdata[INC_W-1:0];
          act_frac <= frac_stage;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tod_step.sv
`timescale 1ns/1ps
module tod_step
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int INC_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [NS_W-1:0]   ns_i,
  input  logic [FRAC_W-1:0] acc_i,
  input  logic [INC_W-1:0]  inc_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [NS_W-1:0]   ns_o,
  output logic [FRAC_W-1:0] acc_o
);
  localparam logic [NS_W:0] WRAP = (NS_W+1)'(BILLION);

  logic          carry;
  logic [NS_W:0] total;

  generate
    if (FRAC_W > 0) begin : g_frac
      logic [FRAC_W:0] acc_sum;
      always_comb begin
        acc_sum = {1'b0, acc_i} + {1'b0, frac_i};
        carry   = acc_sum[FRAC_W];
        acc_o   = acc_sum[FRAC_W-1:0];
      end
    end else begin : g_nofrac
      always_comb begin
        carry = 1'b0;
        acc_o = acc_i;
      end
    end
  endgenerate

  // Advance the nanoseconds and wrap them into seconds.
  always_comb begin
    total = {1'b0, ns_i} + (NS_W+1)'(inc_i) + (NS_W+1)'(carry);
    if (total >= WRAP) begin
      ns_o  = NS_W'(total - WRAP);
      sec_o = sec_i + SEC_W'(1);
    end else begin
      ns_o  = total[NS_W-1:0];
      sec_o = sec_i;
    end
  end
endmodule

// File: rtl/tod_offset.sv
`timescale 1ns/1ps
module tod_offset
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30
) (
  input  logic [SEC_W-1:0] sec_i,
  input  logic [NS_W-1:0]  ns_i,
  input  logic             en,
  input  logic             sub,
  input  logic [NS_W-1:0]  mag,
  output logic [SEC_W-1:0] sec_o,
  output logic [NS_W-1:0]  ns_o
);
  localparam int OW = NS_W + 3;
  localparam logic signed [OW-1:0] ONE_S = OW'(BILLION);
  localparam logic signed [OW-1:0] TWO_S = OW'(2 * 64'(BILLION));

  logic signed [OW-1:0] ns_s, mag_s, r;

  // Apply the signed offset, then carry or borrow up to two seconds.
  always_comb begin
    ns_s  = {3'b000, ns_i};
    mag_s = {3'b000, mag};
    sec_o = sec_i;
    r     = ns_s;
    if (en) begin
      if (!sub) begin
        r = ns_s + mag_s;
        if (r >= TWO_S) begin
          r     = r - TWO_S;
          sec_o = sec_i + SEC_W'(2);
        end else if (r >= ONE_S) begin
          r     = r - ONE_S;
          sec_o = sec_i + SEC_W'(1);
        end
      end else begin
        r = ns_s - mag_s;
        if (r < 0) begin
          r     = r + ONE_S;
          sec_o = sec_i - SEC_W'(1);
          if (r < 0) begin
            r     = r + ONE_S;
            sec_o = sec_i - SEC_W'(2);
          end
        end
      end
    end
    ns_o = r[NS_W-1:0];
  end
endmodule

// File: rtl/ptp_tod_counter.sv
`timescale 1ns/1ps
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int INC_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [SEC_W-1:0]  tod_sec_o,
  output logic [NS_W-1:0]   tod_ns_o
);
  localparam int HI_W = SEC_W - DATA_W;

  logic [SEC_W-1:0]  sec_q, sec_step, sec_offs;
  logic [NS_W-1:0]   ns_q, ns_step, ns_offs;
  logic [FRAC_W-1:0] acc_q, acc_step;
  logic [HI_W-1:0]   sec_hi_stage;
  logic [FRAC_W-1:0] frac_stage, act_frac;
  logic [INC_W-1:0]  act_inc;
  logic              ld_ns, ld_sec, off_en, off_sub;
  logic [NS_W-1:0]   off_mag;

  tod_regs #(
    .SEC_W (SEC_W),
    .NS_W  (NS_W),
    .INC_W (INC_W),
    .FRAC_W(FRAC_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .hi_stage  (sec_hi_stage),
    .frac_stage(frac_stage),
    .act_inc   (act_inc),
    .act_frac  (act_frac),
    .ld_ns     (ld_ns),
    .ld_sec    (ld_sec),
    .off_en    (off_en),
    .off_sub   (off_sub),
    .off_mag   (off_mag)
  );

  tod_step #(
    .SEC_W (SEC_W),
    .NS_W  (NS_W),
    .INC_W (INC_W),
    .FRAC_W(FRAC_W)
  ) u_step (
    .sec_i (sec_q),
    .ns_i  (ns_q),
    .acc_i (acc_q),
    .inc_i (act_inc),
    .frac_i(act_frac),
    .sec_o (sec_step),
    .ns_o  (ns_step),
    .acc_o (acc_step)
  );

  tod_offset #(
    .SEC_W(SEC_W),
    .NS_W (NS_W)
  ) u_offs (
    .sec_i(sec_step),
    .ns_i (ns_step),
    .en   (off_en),
    .sub  (off_sub),
    .mag  (off_mag),
    .sec_o(sec_offs),
    .ns_o (ns_offs)
  );

  // Time registers: loads win over stepping.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
      acc_q <= '0;
    end else begin
      acc_q <= acc_step;
      if (ld_ns) begin
        ns_q <= reg_wdata[NS_W-1:0];
      end else if (ld_sec) begin
        sec_q <= {sec_hi_stage, reg_wdata};
        ns_q  <= ns_step;
      end else begin
        sec_q <= sec_offs;
        ns_q  <= ns_offs;
      end
    end
  end

  // Combinational read mux.
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_NS:     reg_rdata[NS_W-1:0] = ns_q;
      A_SEC_LO: reg_rdata = sec_q[DATA_W-1:0];
      A_SEC_HI: reg_rdata[HI_W-1:0] = sec_q[SEC_W-1:DATA_W];
      A_FRAC:   reg_rdata[FRAC_W-1:0] = frac_stage;
      A_INC: begin
        reg_rdata[INC_W-1:0]       = act_inc;
        reg_rdata[INC_W +: FRAC_W] = act_frac;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign tod_sec_o = sec_q;
  assign tod_ns_o  = ns_q;
endmodule

// File: rtl/ptp_tod_chk.sv
`timescale 1ns/1ps
module ptp_tod_chk
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int INC_W  = 8,
  parameter int FRAC_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_we,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [DATA_W-1:0]       reg_wdata,
  input logic [SEC_W-1:0]        tod_sec_o,
  input logic [NS_W-1:0]         tod_ns_o,
  input logic [INC_W-1:0]        act_inc,
  input logic [FRAC_W-1:0]       act_frac,
  input logic [FRAC_W-1:0]       frac_stage,
  input logic [SEC_W-DATA_W-1:0] sec_hi_stage
);
  localparam logic [NS_W-1:0] WRAP = NS_W'(BILLION);

  assert_ns_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_NS) |=> tod_ns_o < WRAP);

  assert_hi_stage_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SEC_HI) |=>
      (tod_sec_o == $past(tod_sec_o)) || (tod_sec_o == $past(tod_sec_o) + SEC_W'(1)));

  assert_frac_stage_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_FRAC) |=> $stable(act_frac));

  assert_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_INC) |=>
      (act_inc == $past(reg_wdata[INC_W-1:0])) && (act_frac == $past(frac_stage)));

  assert_sec_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SEC_LO) |=>
      tod_sec_o == {$past(sec_hi_stage), $past(reg_wdata)});

  assert_zero_rate_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_inc == '0 && act_frac == '0 && !reg_we && tod_ns_o < WRAP) |=>
      ($stable(tod_ns_o) && $stable(tod_sec_o)));
endmodule

bind ptp_tod_counter ptp_tod_chk #(
  .SEC_W (SEC_W),
  .NS_W  (NS_W),
  .INC_W (INC_W),
  .FRAC_W(FRAC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .tod_sec_o   (tod_sec_o),
  .tod_ns_o    (tod_ns_o),
  .act_inc     (act_inc),
  .act_frac    (act_frac),
  .frac_stage  (frac_stage),
  .sec_hi_stage(sec_hi_stage)
);

// File: tb/ptp_tod_counter_tb.sv
`timescale 1ns/1ps
module ptp_tod_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [47:0] tod_sec_o;
  logic [29:0] tod_ns_o;

  always #2.5 clk = ~clk;

  ptp_tod_counter u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .tod_sec_o(tod_sec_o),
    .tod_ns_o (tod_ns_o)
  );

  localparam longint BIL   = 64'd1000000000;
  localparam longint SMASK = (64'd1 << 48) - 1;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  longint m_sec, m_ns, m_acc, m_inc, m_frac, m_fst, m_hst;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycle model built from the requirements.
  task automatic model_step(bit we, int addr, logic [31:0] d);
    longint acc2, c, t, s, dv, mag;
    dv   = longint'({32'd0, d});
    acc2 = m_acc + m_frac;
    c    = acc2 >> 16;
    acc2 = acc2 & 64'hffff;
    t    = m_ns + m_inc + c;
    s    = m_sec;
    if (t >= BIL) begin
      t = t - BIL;
      s = (s + 1) & SMASK;
    end
    m_acc = acc2;
    if (we && addr == 0) begin
      m_ns = dv & 64'h3fffffff;
    end else if (we && addr == 1) begin
      m_sec = ((m_hst << 32) | dv) & SMASK;
      m_ns  = t;
    end else begin
      if (we && addr == 5) begin
        mag = dv & 64'h3fffffff;
        if (!d[31]) begin
          t = t + mag;
          if (t >= 2 * BIL) begin
            t = t - 2 * BIL;
            s = s + 2;
          end else if (t >= BIL) begin
            t = t - BIL;
            s = s + 1;
          end
        end else begin
          t = t - mag;
          if (t < 0) begin
            t = t + BIL;
            s = s - 1;
            if (t < 0) begin
              t = t + BIL;
              s = s - 1;
            end
          end
        end
        s = s & SMASK;
      end
      m_sec = s;
      m_ns  = t;
      if (we && addr == 2) m_hst = dv & 64'hffff;
      if (we && addr == 3) m_fst = dv & 64'hffff;
      if (we && addr == 4) begin
        m_inc  = dv & 64'hff;
        m_frac = m_fst;
      end
    end
  endtask

  function automatic longint exp_rd(int addr);
    case (addr)
      0: return m_ns;
      1: return m_sec & 64'hffffffff;
      2: return m_sec >> 32;
      3: return m_fst;
      4: return (m_frac << 8) | m_inc;
      default: return 0;
    endcase
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic cyc(bit we, int addr, logic [31:0] d);
    reg_we    = we;
    reg_addr  = addr[2:0];
    reg_wdata = d;
    model_step(we, addr, d);
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic cmp_time(string tag);
    chk({tag, " sec"}, longint'(tod_sec_o), m_sec);
    chk({tag, " ns"},  longint'(tod_ns_o),  m_ns);
  endtask

  task automatic rd(int addr, string tag);
    reg_addr = addr[2:0];
    #0.5;
    chk(tag, longint'(reg_rdata), exp_rd(addr));
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed      = 12345;
    void'($urandom(seed));
    rst_n     = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    m_sec = 0; m_ns = 0; m_acc = 0; m_inc = 0; m_frac = 0; m_fst = 0; m_hst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state and zero-rate hold.
    cmp_time("R1 reset");
    for (int a = 0; a < 8; a++) rd(a, "R1 R10 reset read");
    repeat (5) cyc(0, 0, 0);
    cmp_time("R1 zero rate hold");

    // R4: fraction only stages until the whole part is written.
    cyc(1, 3, 32'h0000_8000);
    rd(3, "R4 staged fraction");
    rd(4, "R4 not yet committed");
    repeat (3) cyc(0, 0, 0);
    cmp_time("R4 staging has no effect");
    cyc(1, 4, 32'd8);
    rd(4, "R4 commit");

    // R2: whole part plus fractional carry each cycle.
    for (int i = 0; i < 6; i++) begin
      cyc(0, 0, 0);
      cmp_time("R2 advance");
    end

    // R5 / R6: upper seconds staged, committed by lower write.
    cyc(1, 2, 32'h0000_0012);
    rd(2, "R5 upper staged only");
    cmp_time("R5 live time");
    cyc(1, 1, 32'h89ab_cdef);
    cmp_time("R6 seconds load");
    rd(1, "R10 read seconds low");
    rd(2, "R10 read seconds high");
    rd(5, "R10 offset reads zero");

    // R7 / R3: nanosecond load then rollover.
    cyc(1, 0, 32'd999_999_990);
    cmp_time("R7 ns load");
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0);
      cmp_time("R3 rollover");
      rd(0, "R11 read matches bus");
    end

    // R8: adding offsets, single and double carry.
    cyc(1, 5, 32'd500);
    cmp_time("R8 add");
    cyc(1, 0, 32'd999_999_000);
    cyc(1, 5, 32'h3fff_ffff);
    cmp_time("R8 double carry");

    // R9: subtracting offsets, borrow and wrap.
    cyc(1, 5, 32'h8000_0000 | 32'd999_999_999);
    cmp_time("R9 borrow");
    cyc(1, 2, 32'd0);
    cyc(1, 1, 32'd0);
    cyc(1, 0, 32'd5);
    cyc(1, 5, 32'h8000_0000 | 32'd100);
    cmp_time("R9 wrap below zero");
    cyc(1, 0, 32'd10);
    cyc(1, 5, 32'hbfff_ffff);
    cmp_time("R9 double borrow");

    // Random mix against the model.
    for (int i = 0; i < 1500; i++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom % 16);
      d  = $urandom;
      case (op)
        0: cyc(1, 0, (i % 7 == 0) ? (d & 32'h3fff_ffff) : (d % 32'd1_000_000_000));
        1: cyc(1, 1, d);
        2: cyc(1, 2, d);
        3: cyc(1, 3, d);
        4: cyc(1, 4, d);
        5: cyc(1, 5, d);
        6: cyc(1, int'($urandom % 8), d);
        default: cyc(0, 0, 0);
      endcase
      cmp_time("R2 random model");
      if (op == 7) rd(int'($urandom % 8), "R10 random read");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule